// File: doc/BRIEF.md
# Bidirectional 12-bit Serial Link Converter

This block turns a 12-bit parallel word into a framed serial stream with a forwarded bit clock, or takes a framed serial stream and rebuilds 12-bit words. A single direction input picks the role. When serializing, the parallel pins are inputs. When deserializing, the block drives them. An inverted copy of the direction input comes out combinationally, so one device can steer the role of a second device at the far end of the link.

Two mode pins select either power-down or one of three reference-clock range codes. Power-down overrides the direction input. A serial frame is 14 bits long: a 1 start bit, then the twelve data bits with the most significant bit first, then a 0 stop bit. The serializer sends one bit for every system clock cycle. The deserializer takes one bit on each rising edge of the incoming bit clock, and it samples that bit clock with the system clock.

Words enter through a strobe and leave through a word clock pulse. `ser_ready` is the back-pressure signal. A strobe rising edge is taken only while `ser_ready` is high. A strobe edge seen while `ser_ready` is low is dropped and is not queued. The deserializer output has no back-pressure: every valid frame overwrites the parallel output register.

Top module: `bdsd_top`

## Requirements
- R1: With `dir_in`=1 and not powered down, the block serializes. With `dir_in`=0 and not powered down, it deserializes.
- R2: `dir_out` is always the logical inverse of `dir_in`, with no clock involved.
- R3: `par_oe` (parallel pins driven) is 1 only while deserializing. It is 0 while serializing and during power-down.
- R4: With `mode_pins`=00 the block is powered down. `pwr_down` is 1, `par_oe` is 0, the serial clock output stays low, strobes are ignored, and received bits do not change `par_out`.
- R5: `range_sel` is 0 for `mode_pins`=00, 1 for 01 (20–56 MHz), 2 for 10 (5–15 MHz) and 3 for 11 (10–30 MHz).
- R6: A strobe rising edge while `ser_ready`=1 loads `par_in`. The serializer samples the strobe on a clock edge. From the next cycle, `ser_clk_out` stays high for 14 cycles while `ser_data_out` carries start bit 1, data bits 11 down to 0, and stop bit 0. The line is 0 when idle.
- R7: While a frame is being sent, `ser_ready`=0. A strobe edge in that time is ignored, and the frame in flight is not altered.
- R8: The deserializer ignores 0 bits while it waits for a start bit. After the 14th bit of a frame with a valid stop bit, `par_out` takes data bits 11..0 in the cycle after that bit's clock edge is sampled. In that same cycle `word_clk` is high, for exactly one cycle.
- R9: A frame whose stop bit is 1 is discarded: no `word_clk` pulse, and `par_out` is unchanged.
- R10: `par_out` keeps its last value while the block is a serializer, and it keeps that value after the block turns back into a deserializer, until a new valid frame arrives.
- R11: Any change of `dir_in` clears any partly received or partly sent frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_in | input | 1 | 1 = serializer, 0 = deserializer |
| dir_out | output | 1 | Inverse of dir_in |
| mode_pins | input | 2 | Mode select, bit 1 = upper pin, bit 0 = lower pin |
| range_sel | output | 2 | Decoded reference range code |
| pwr_down | output | 1 | High in power-down |
| par_in | input | 12 | Parallel word to serialize |
| par_out | output | 12 | Last received parallel word |
| par_oe | output | 1 | Parallel pin drive enable |
| strobe | input | 1 | Rising edge loads par_in |
| ser_ready | output | 1 | Serializer can accept a strobe |
| ser_clk_out | output | 1 | Forwarded bit clock (high per bit) |
| ser_data_out | output | 1 | Serial data out |
| des_clk_in | input | 1 | Incoming bit clock |
| des_data_in | input | 1 | Incoming serial data |
| word_clk | output | 1 | One-cycle pulse per accepted word |

## Verification
The bench aims at the turn-around cases. It stops a frame halfway by flipping direction and then sends a clean frame. A design that kept the stale bit count would misalign that frame and store the wrong word. The bench also swaps roles after a received word. A design that cleared `par_out` on the swap would lose the held value. It sends a frame with a bad stop bit, which a design that ignored framing would accept. It raises a second strobe while a frame is still going out, which a design without back-pressure would use to corrupt the frame in flight. It checks power-down with both directions, because a decode that favoured `dir_in` would still drive the parallel pins or clock out bits.

// File: rtl/bdsd_pkg.sv
package bdsd_pkg;
  typedef enum logic [1:0] {
    RANGE_OFF   = 2'd0,
    RANGE_20_56 = 2'd1,
    RANGE_5_15  = 2'd2,
    RANGE_10_30 = 2'd3
  } range_e;

  function automatic range_e decode_range(input logic [1:0] pins);
    case (pins)
      2'b01:   return RANGE_20_56;
      2'b10:   return RANGE_5_15;
      2'b11:   return RANGE_10_30;
      default: return RANGE_OFF;
    endcase
  endfunction
endpackage

// File: rtl/bdsd_mode_dec.sv
module bdsd_mode_dec
  import bdsd_pkg::*;
(
  input  logic [1:0] mode_pins,
  input  logic       dir_in,
  output range_e     range_code,
  output logic       pd,
  output logic       ser_en,
  output logic       des_en
);
  always_comb begin
    range_code = decode_range(mode_pins);
    pd         = (range_code == RANGE_OFF);
    ser_en     = !pd && dir_in;
    des_en     = !pd && !dir_in;
  end
endmodule

// File: rtl/bdsd_ser.sv
module bdsd_ser #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             flush,
  input  logic             strobe,
  input  logic [WIDTH-1:0] par_in,
  output logic             ready,
  output logic             bit_clk,
  output logic             bit_data
);
  localparam int FRAME = WIDTH + 2;
  localparam int CW    = $clog2(FRAME + 1);

  logic [FRAME-1:0] sh;
  logic [CW-1:0]    left;
  logic             strobe_q;
  logic             busy;
  logic             load;

  assign busy = (left != '0);
  assign load = en && !busy && strobe && !strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      left     <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (flush) begin
        sh   <= '0;
        left <= '0;
      end else if (load) begin
        sh   <= {1'b1, par_in, 1'b0};
        left <= CW'(FRAME);
      end else if (busy) begin
        sh   <= {sh[FRAME-2:0], 1'b0};
        left <= left - CW'(1);
      end
    end
  end

  assign ready    = en && !busy;
  assign bit_clk  = busy;
  assign bit_data = busy && sh[FRAME-1];

  // R6: the first bit of every frame is the start bit
  p_start_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_clk) |-> bit_data);

  // R7: a frame in flight only counts down, strobes cannot reload it
  p_busy_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush) |=> (left == $past(left) - CW'(1)));
endmodule

// File: rtl/bdsd_des.sv
module bdsd_des #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             flush,
  input  logic             bit_clk,
  input  logic             bit_data,
  output logic [WIDTH-1:0] word,
  output logic             word_clk
);
  localparam int FRAME = WIDTH + 2;
  localparam int CW    = $clog2(FRAME + 1);

  logic [FRAME-2:0] sh;
  logic [CW-1:0]    cnt;
  logic             clk_q;
  logic [WIDTH-1:0] word_q;
  logic             wc;
  logic             take;
  logic [FRAME-1:0] frame;

  assign take  = en && bit_clk && !clk_q;
  assign frame = {sh, bit_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      clk_q  <= 1'b0;
      word_q <= '0;
      wc     <= 1'b0;
    end else begin
      clk_q <= bit_clk;
      wc    <= 1'b0;
      if (flush) begin
        sh  <= '0;
        cnt <= '0;
      end else if (take) begin
        if (cnt == '0 && !bit_data) begin
          cnt <= '0;
        end else if (cnt == CW'(FRAME - 1)) begin
          cnt <= '0;
          sh  <= '0;
          if (frame[FRAME-1] && !frame[0]) begin
            word_q <= frame[FRAME-2:1];
            wc     <= 1'b1;
          end
        end else begin
          sh  <= {sh[FRAME-3:0], bit_data};
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign word     = word_q;
  assign word_clk = wc;

  // R8: word clock is a single-cycle pulse
  p_wc_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wc |=> !wc);

  // R9: a word is only announced after a zero stop bit
  p_stop_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wc |-> !$past(bit_data));

  // R10: the held word cannot move while the receiver is disabled
  p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(word_q));
endmodule

// File: rtl/bdsd_top.sv
module bdsd_top
  import bdsd_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_in,
  output logic             dir_out,
  input  logic [1:0]       mode_pins,
  output logic [1:0]       range_sel,
  output logic             pwr_down,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] par_out,
  output logic             par_oe,
  input  logic             strobe,
  output logic             ser_ready,
  output logic             ser_clk_out,
  output logic             ser_data_out,
  input  logic             des_clk_in,
  input  logic             des_data_in,
  output logic             word_clk
);
  range_e range_code;
  logic   pd, ser_en, des_en;
  logic   dir_q, flush;

  bdsd_mode_dec u_dec (
    .mode_pins (mode_pins),
    .dir_in    (dir_in),
    .range_code(range_code),
    .pd        (pd),
    .ser_en    (ser_en),
    .des_en    (des_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_in;
  end

  assign flush = pd || (dir_in != dir_q);

  bdsd_ser #(.WIDTH(WIDTH)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ser_en),
    .flush   (flush),
    .strobe  (strobe),
    .par_in  (par_in),
    .ready   (ser_ready),
    .bit_clk (ser_clk_out),
    .bit_data(ser_data_out)
  );

  bdsd_des #(.WIDTH(WIDTH)) u_des (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (des_en),
    .flush   (flush),
    .bit_clk (des_clk_in),
    .bit_data(des_data_in),
    .word    (par_out),
    .word_clk(word_clk)
  );

  assign dir_out   = ~dir_in;
  assign range_sel = range_code;
  assign pwr_down  = pd;
  assign par_oe    = des_en;

  // R4: power-down silences the serial clock from the next cycle on
  p_pd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !ser_clk_out);
endmodule

// File: tb/bdsd_top_test.sv
module bdsd_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_in = 1'b0;
  logic        dir_out;
  logic [1:0]  mode_pins = 2'b01;
  logic [1:0]  range_sel;
  logic        pwr_down;
  logic [11:0] par_in = '0;
  logic [11:0] par_out;
  logic        par_oe;
  logic        strobe = 1'b0;
  logic        ser_ready;
  logic        ser_clk_out;
  logic        ser_data_out;
  logic        des_clk_in = 1'b0;
  logic        des_data_in = 1'b0;
  logic        word_clk;

  int total = 0;
  int bad = 0;
  logic wc_seen;

  always #10 clk = ~clk;

  bdsd_top uut (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .dir_out(dir_out),
    .mode_pins(mode_pins), .range_sel(range_sel), .pwr_down(pwr_down),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe), .strobe(strobe),
    .ser_ready(ser_ready), .ser_clk_out(ser_clk_out), .ser_data_out(ser_data_out),
    .des_clk_in(des_clk_in), .des_data_in(des_data_in), .word_clk(word_clk)
  );

  // bit 12 = direction, bits 11:0 = word
  localparam logic [12:0] VEC [0:5] = '{
    13'h1A5C, 13'h03F1, 13'h1FFF, 13'h0800, 13'h1001, 13'h0ABC
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_ser(input logic [11:0] w, input string req);
    logic [13:0] fr;
    fr = {1'b1, w, 1'b0};
    @(negedge clk); par_in = w; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    for (int i = 0; i < 14; i++) begin
      chk(req, ser_clk_out, 1);
      chk(req, ser_data_out, fr[13-i]);
      @(negedge clk);
    end
    chk(req, ser_clk_out, 0);
    chk(req, ser_data_out, 0);
  endtask

  task automatic des_bits(input logic [13:0] fr, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); des_data_in = fr[13-i]; des_clk_in = 1'b1;
      @(negedge clk); des_clk_in = 1'b0;
      wc_seen = word_clk;
    end
  endtask

  task automatic send_des(input logic [11:0] w, input logic stop, input logic [11:0] exp_word, input string req);
    des_bits({1'b1, w, stop}, 14);
    chk(req, wc_seen, !stop);
    chk(req, par_out, exp_word);
    @(negedge clk);
    chk(req, word_clk, 0);
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    // reset state
    chk("R6 reset", ser_clk_out, 0);
    chk("R8 reset", word_clk, 0);
    chk("R10 reset", par_out, 0);
    rst_n = 1'b1;
    idle(2);

    // vector table walk (R1, R6, R8)
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); dir_in = VEC[i][12];
      idle(2);
      if (VEC[i][12]) begin
        chk("R1 ser oe", par_oe, 0);
        send_ser(VEC[i][11:0], "R6");
      end else begin
        chk("R1 des oe", par_oe, 1);
        des_bits(14'h0, 2);
        send_des(VEC[i][11:0], 1'b0, VEC[i][11:0], "R8");
      end
    end

    // R2 / R3 direction pass-through and drive enable
    @(negedge clk); dir_in = 1'b1; #1;
    chk("R2", dir_out, 0);
    chk("R3", par_oe, 0);
    dir_in = 1'b0; #1;
    chk("R2", dir_out, 1);
    chk("R3", par_oe, 1);

    // R5 range decode
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); mode_pins = 2'(m); #1;
      chk("R5", range_sel, m);
    end

    // R4 power-down with both directions
    @(negedge clk); mode_pins = 2'b00; dir_in = 1'b0;
    idle(2);
    chk("R4 pd", pwr_down, 1);
    chk("R4 oe", par_oe, 0);
    des_bits({1'b1, 12'h123, 1'b0}, 14);
    chk("R4 no word", wc_seen, 0);
    chk("R4 par_out", par_out, 12'hABC);
    @(negedge clk); dir_in = 1'b1; par_in = 12'h555; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    chk("R4 no ser", ser_clk_out, 0);
    chk("R4 oe ser", par_oe, 0);
    idle(2);
    chk("R4 no ser late", ser_clk_out, 0);
    @(negedge clk); mode_pins = 2'b10;
    idle(2);
    chk("R4 leave pd", pwr_down, 0);

    // R7 strobe during a frame
    @(negedge clk); par_in = 12'hC3A; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    chk("R7 ready low", ser_ready, 0);
    for (int i = 0; i < 14; i++) begin
      logic [13:0] fr;
      fr = {1'b1, 12'hC3A, 1'b0};
      if (i == 4) begin par_in = 12'h0F0; strobe = 1'b1; end
      if (i == 6) strobe = 1'b0;
      chk("R7 frame", ser_data_out, fr[13-i]);
      @(negedge clk);
    end
    chk("R7 no extra", ser_clk_out, 0);
    chk("R7 ready back", ser_ready, 1);

    // R10 hold across turn-around
    @(negedge clk); dir_in = 1'b0;
    idle(2);
    send_des(12'h6D2, 1'b0, 12'h6D2, "R10 load");
    @(negedge clk); dir_in = 1'b1;
    idle(2);
    send_ser(12'h111, "R10 ser");
    chk("R10 held ser", par_out, 12'h6D2);
    @(negedge clk); dir_in = 1'b0;
    idle(2);
    chk("R10 held back", par_out, 12'h6D2);

    // R9 bad stop bit
    send_des(12'h2B4, 1'b1, 12'h6D2, "R9");

    // R11 partial frame flushed by turn-around
    des_bits({1'b1, 12'hFFF, 1'b0}, 7);
    @(negedge clk); dir_in = 1'b1;
    idle(2);
    @(negedge clk); dir_in = 1'b0;
    idle(2);
    send_des(12'h49E, 1'b0, 12'h49E, "R11");

    // R11 partial serial frame flushed
    @(negedge clk); dir_in = 1'b1;
    idle(2);
    @(negedge clk); par_in = 12'h7E7; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    idle(3);
    dir_in = 1'b0;
    idle(2);
    chk("R11 ser flush", ser_clk_out, 0);
    @(negedge clk); dir_in = 1'b1;
    idle(2);
    chk("R11 ser idle", ser_clk_out, 0);
    send_ser(12'h3C5, "R11 ser new");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule